// File: doc/BRIEF.md
# Dual-Pipe Pairing Issue Control

This block steers instructions through the issue control of a superscalar integer core. The core has two five-stage pipes. The U pipe takes any instruction. The V pipe takes only simple ones. Each cycle, up to two instructions arrive from the prefetch side, lane 0 being the older. They move together into the first decode stage. There the block decides whether the pair may enter address generation side by side, or whether the younger one must wait.

Each instruction is a small record: an opaque tag, a simple/complex class bit, a destination write enable, a destination register index and two source register indices. When the pair cannot go together, the older instruction enters U alone and a bubble enters V. The younger instruction moves into the U slot of the decode stage and issues on the next cycle. While that happens, the prefetch stage holds its contents and the block refuses new input. A stall input freezes every stage of both pipes.

Top module: `pair_issue`

## Requirements
- R1: All five stages of both pipes advance together on every unstalled cycle, in the order prefetch (stage index 0), first decode (1), address generation (2), execute (3), write-back (4). Valid bit and tag of stage s appear at bit s of `u_vld`/`v_vld` and at bits [s*TAG_W +: TAG_W] of `u_tags`/`v_tags`.
- R2: The older decode-stage instruction (lane 0, the U slot) always enters U at address generation, whatever its class.
- R3: The younger instruction enters V together with the older one only if its class bit `simple` is 1 and there is no register dependency on the older one. Otherwise a V bubble is inserted.
- R4: A dependency exists when the older has `wr`=1 and its `rd` equals the younger's `rs1`, or its `rs2`, or (when the younger has `wr`=1) its `rd`. Both source fields always count as read. A destination field with `wr`=0 is never compared.
- R5: On a failed pairing, the younger instruction takes the U slot of the decode stage and enters U alone on the next unstalled cycle. In the failing cycle `in_ready` is 0 and the prefetch stage keeps its contents.
- R6: While `stall` is 1, every valid bit and tag of both pipes holds, `in_ready` is 0 and `issue_cnt` is 0.
- R7: `issue_cnt` gives the number of instructions that enter address generation at the coming edge: 0, 1 or 2.
- R8: A synchronous reset clears every stage valid bit of both pipes.
- R9: An input with only lane 1 valid (`in_vld`=2'b10) is placed in the U slot of the prefetch stage, and the V slot stays empty.
- R10: Input offered while `in_ready` is 0 is not taken into the pipes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze all stages |
| in_vld | input | 2 | Lane valid bits, bit 0 older |
| in0_tag | input | TAG_W | Lane 0 tag |
| in0_simple | input | 1 | Lane 0 class: 1 = simple |
| in0_wr | input | 1 | Lane 0 writes a register |
| in0_rd | input | RW | Lane 0 destination index |
| in0_rs1 | input | RW | Lane 0 first source |
| in0_rs2 | input | RW | Lane 0 second source |
| in1_tag | input | TAG_W | Lane 1 tag |
| in1_simple | input | 1 | Lane 1 class: 1 = simple |
| in1_wr | input | 1 | Lane 1 writes a register |
| in1_rd | input | RW | Lane 1 destination index |
| in1_rs1 | input | RW | Lane 1 first source |
| in1_rs2 | input | RW | Lane 1 second source |
| in_ready | output | 1 | Input accepted at the coming edge |
| issue_cnt | output | 2 | Instructions entering address generation |
| u_vld | output | 5 | U pipe stage valid bits |
| v_vld | output | 5 | V pipe stage valid bits |
| u_tags | output | 5*TAG_W | U pipe stage tags |
| v_tags | output | 5*TAG_W | V pipe stage tags |

## Verification
A failed pairing in decode can fall in the same cycle as the arrival of the next pair at the block's input. The bench provokes this by streaming three pairs back to back, the first of them dependent. It then judges that `in_ready` drops for exactly that cycle, that the prefetch U tag still shows the second pair afterwards, and that the third pair enters only once. A stall that falls on a cycle with a full pair in decode and new input offered is judged the same way, through frozen valid bits and tags and the absence of the offered tag.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int TAG_W = 8,
  parameter int RW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic [1:0]         in_vld,
  input  logic [TAG_W-1:0]   in0_tag,
  input  logic               in0_simple,
  input  logic               in0_wr,
  input  logic [RW-1:0]      in0_rd,
  input  logic [RW-1:0]      in0_rs1,
  input  logic [RW-1:0]      in0_rs2,
  input  logic [TAG_W-1:0]   in1_tag,
  input  logic               in1_simple,
  input  logic               in1_wr,
  input  logic [RW-1:0]      in1_rd,
  input  logic [RW-1:0]      in1_rs1,
  input  logic [RW-1:0]      in1_rs2,
  output logic               in_ready,
  output logic [1:0]         issue_cnt,
  output logic [4:0]         u_vld,
  output logic [4:0]         v_vld,
  output logic [5*TAG_W-1:0] u_tags,
  output logic [5*TAG_W-1:0] v_tags
);

  localparam int NST = 5;
  localparam int PF = 0, D1 = 1, D2 = 2, EX = 3, WB = 4;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             simple;
    logic             wr;
    logic [RW-1:0]    rd;
    logic [RW-1:0]    rs1;
    logic [RW-1:0]    rs2;
  } ins_t;

  ins_t u_st [NST];
  ins_t v_st [NST];
  logic [NST-1:0] u_v, v_v;

  ins_t in0, in1, new_u;
  assign in0   = '{in0_tag, in0_simple, in0_wr, in0_rd, in0_rs1, in0_rs2};
  assign in1   = '{in1_tag, in1_simple, in1_wr, in1_rd, in1_rs1, in1_rs2};
  assign new_u = in_vld[0] ? in0 : in1;

  logic dep, pair_ok, split, adv;
  assign dep = u_st[D1].wr &&
               (v_st[D1].rs1 == u_st[D1].rd || v_st[D1].rs2 == u_st[D1].rd ||
                (v_st[D1].wr && v_st[D1].rd == u_st[D1].rd));
  assign pair_ok   = u_v[D1] && v_v[D1] && v_st[D1].simple && !dep;
  assign split     = u_v[D1] && v_v[D1] && !pair_ok;
  assign adv       = !stall;
  assign in_ready  = adv && !split;
  assign issue_cnt = (!adv || !u_v[D1]) ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      u_v <= '0;
      v_v <= '0;
    end else if (adv) begin
      for (int s = EX; s <= WB; s++) begin
        u_v[s]  <= u_v[s-1];
        v_v[s]  <= v_v[s-1];
        u_st[s] <= u_st[s-1];
        v_st[s] <= v_st[s-1];
      end
      u_v[D2]  <= u_v[D1];
      u_st[D2] <= u_st[D1];
      v_v[D2]  <= pair_ok;
      v_st[D2] <= v_st[D1];
      if (split) begin
        u_v[D1]  <= 1'b1;
        u_st[D1] <= v_st[D1];
        v_v[D1]  <= 1'b0;
      end else begin
        u_v[D1]  <= u_v[PF];
        u_st[D1] <= u_st[PF];
        v_v[D1]  <= v_v[PF];
        v_st[D1] <= v_st[PF];
        u_v[PF]  <= |in_vld;
        u_st[PF] <= new_u;
        v_v[PF]  <= &in_vld;
        v_st[PF] <= in1;
      end
    end
  end

  assign u_vld = u_v;
  assign v_vld = v_v;

  for (genvar s = 0; s < NST; s++) begin : g_tags
    assign u_tags[s*TAG_W +: TAG_W] = u_st[s].tag;
    assign v_tags[s*TAG_W +: TAG_W] = v_st[s].tag;
  end

  // R3
  v_simple_chk: assert property (@(posedge clk) disable iff (rst)
    v_v[D2] |-> v_st[D2].simple);

  // R4
  v_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (v_v[D2] && u_st[D2].wr) |->
      (v_st[D2].rs1 != u_st[D2].rd && v_st[D2].rs2 != u_st[D2].rd &&
       !(v_st[D2].wr && v_st[D2].rd == u_st[D2].rd)));

  // R2
  v_needs_u_chk: assert property (@(posedge clk) disable iff (rst)
    v_v[D2] |-> u_v[D2]);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(u_vld) && $stable(v_vld) && $stable(u_tags) && $stable(v_tags)));

  // R1
  lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (u_vld[4:3] == $past(u_vld[3:2]) && v_vld[4:3] == $past(v_vld[3:2])));

  // R7
  issue_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (u_vld[2] == ($past(issue_cnt) != 2'd0) && v_vld[2] == ($past(issue_cnt) == 2'd2)));

  // R5
  split_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !in_ready) |=> ($stable(u_tags[TAG_W-1:0]) && u_vld[1] && !v_vld[1]));

endmodule

// File: tb/pair_issue_tb_top.sv
`timescale 1ns/1ps
module pair_issue_tb_top;
  localparam int TW = 8;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, stall;
  logic [1:0] in_vld;
  logic [TW-1:0] in0_tag, in1_tag;
  logic in0_simple, in0_wr, in1_simple, in1_wr;
  logic [RW-1:0] in0_rd, in0_rs1, in0_rs2, in1_rd, in1_rs1, in1_rs2;
  logic in_ready;
  logic [1:0] issue_cnt;
  logic [4:0] u_vld, v_vld;
  logic [5*TW-1:0] u_tags, v_tags;

  pair_issue #(.TAG_W(TW), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .stall(stall), .in_vld(in_vld),
    .in0_tag(in0_tag), .in0_simple(in0_simple), .in0_wr(in0_wr),
    .in0_rd(in0_rd), .in0_rs1(in0_rs1), .in0_rs2(in0_rs2),
    .in1_tag(in1_tag), .in1_simple(in1_simple), .in1_wr(in1_wr),
    .in1_rd(in1_rd), .in1_rs1(in1_rs1), .in1_rs2(in1_rs2),
    .in_ready(in_ready), .issue_cnt(issue_cnt),
    .u_vld(u_vld), .v_vld(v_vld), .u_tags(u_tags), .v_tags(v_tags));

  typedef struct packed {
    logic [7:0] t0; logic s0; logic w0; logic [2:0] d0; logic [2:0] a0; logic [2:0] b0;
    logic [7:0] t1; logic s1; logic w1; logic [2:0] d1; logic [2:0] a1; logic [2:0] b1;
    logic [1:0] cnt;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{8'h10,1'b1,1'b1,3'd1,3'd2,3'd3, 8'h11,1'b1,1'b1,3'd6,3'd4,3'd5, 2'd2},
    '{8'h20,1'b1,1'b1,3'd1,3'd2,3'd3, 8'h21,1'b0,1'b1,3'd6,3'd4,3'd5, 2'd1},
    '{8'h30,1'b1,1'b1,3'd2,3'd3,3'd4, 8'h31,1'b1,1'b1,3'd5,3'd2,3'd6, 2'd1},
    '{8'h40,1'b1,1'b1,3'd2,3'd3,3'd4, 8'h41,1'b1,1'b1,3'd5,3'd6,3'd2, 2'd1},
    '{8'h50,1'b1,1'b1,3'd2,3'd3,3'd4, 8'h51,1'b1,1'b1,3'd2,3'd5,3'd6, 2'd1},
    '{8'h60,1'b1,1'b0,3'd2,3'd3,3'd4, 8'h61,1'b1,1'b1,3'd2,3'd2,3'd2, 2'd2},
    '{8'h70,1'b1,1'b1,3'd2,3'd3,3'd4, 8'h71,1'b1,1'b0,3'd2,3'd5,3'd6, 2'd2},
    '{8'h80,1'b0,1'b1,3'd1,3'd2,3'd3, 8'h81,1'b1,1'b1,3'd6,3'd4,3'd5, 2'd2}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int utag(int s); return int'(u_tags[s*TW +: TW]); endfunction
  function automatic int vtag(int s); return int'(v_tags[s*TW +: TW]); endfunction

  task automatic drive(vec_t v, logic [1:0] lanes);
    in_vld = lanes;
    in0_tag = v.t0; in0_simple = v.s0; in0_wr = v.w0; in0_rd = v.d0; in0_rs1 = v.a0; in0_rs2 = v.b0;
    in1_tag = v.t1; in1_simple = v.s1; in1_wr = v.w1; in1_rd = v.d1; in1_rs1 = v.a1; in1_rs2 = v.b1;
  endtask

  task automatic drain();
    in_vld = 2'b00;
    repeat (6) @(negedge clk);
    check("R1 drain u", int'(u_vld), 0);
    check("R1 drain v", int'(v_vld), 0);
  endtask

  initial begin
    vec_t c;
    rst = 1'b1; stall = 1'b0;
    drive(VT[0], 2'b00);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset u_vld", int'(u_vld), 0);
    check("R8 reset v_vld", int'(v_vld), 0);
    check("R7 reset issue_cnt", int'(issue_cnt), 0);
    check("R10 reset in_ready", int'(in_ready), 1);

    for (int i = 0; i < 8; i++) begin
      drive(VT[i], 2'b11);
      @(negedge clk);
      in_vld = 2'b00;
      check("R1 prefetch both lanes", int'({u_vld[0], v_vld[0]}), 3);
      @(negedge clk);
      check("R7 R3 R4 issue_cnt", int'(issue_cnt), int'(VT[i].cnt));
      check("R5 in_ready on pairing", int'(in_ready), int'(VT[i].cnt == 2'd2));
      @(negedge clk);
      check("R2 older in U", utag(2), int'(VT[i].t0));
      check("R3 V valid", int'(v_vld[2]), int'(VT[i].cnt == 2'd2));
      if (VT[i].cnt == 2'd2) begin
        check("R3 younger in V", vtag(2), int'(VT[i].t1));
      end else begin
        check("R5 single issue pending", int'(issue_cnt), 1);
        check("R5 younger in U slot", utag(1), int'(VT[i].t1));
        @(negedge clk);
        check("R5 younger enters U", utag(2), int'(VT[i].t1));
        check("R5 no V", int'(v_vld[2]), 0);
        check("R1 older in execute", utag(3), int'(VT[i].t0));
      end
      drain();
    end

    // R6 and R10: stall with a pair in decode and new input offered
    drive(VT[0], 2'b11);
    @(negedge clk);
    in_vld = 2'b00;
    @(negedge clk);
    stall = 1'b1;
    c = VT[0]; c.t0 = 8'hEE; c.t1 = 8'hEF;
    drive(c, 2'b11);
    #0.1;
    check("R6 issue_cnt under stall", int'(issue_cnt), 0);
    check("R6 in_ready under stall", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    check("R6 u frozen", int'(u_vld), 5'b00010);
    check("R6 v frozen", int'(v_vld), 5'b00010);
    check("R6 tag frozen", utag(1), 8'h10);
    stall = 1'b0;
    in_vld = 2'b00;
    @(negedge clk);
    check("R10 stalled input dropped", int'(u_vld), 5'b00100);
    check("R6 pair resumes", int'(v_vld), 5'b00100);
    drain();

    // R9: lane 1 alone
    c = VT[0]; c.t1 = 8'h77;
    drive(c, 2'b10);
    @(negedge clk);
    in_vld = 2'b00;
    check("R9 U valid", int'(u_vld), 5'b00001);
    check("R9 V empty", int'(v_vld), 0);
    check("R9 U tag", utag(0), 8'h77);
    drain();

    // R5 and R10: split meets streamed input
    drive(VT[2], 2'b11);
    @(negedge clk);
    drive(VT[0], 2'b11);
    @(negedge clk);
    c = VT[0]; c.t0 = 8'hC0; c.t1 = 8'hC1;
    drive(c, 2'b11);
    #0.1;
    check("R5 in_ready low on split", int'(in_ready), 0);
    @(negedge clk);
    check("R5 in_ready back", int'(in_ready), 1);
    check("R5 prefetch held", utag(0), 8'h10);
    check("R5 single pending", int'(issue_cnt), 1);
    @(negedge clk);
    in_vld = 2'b00;
    check("R5 younger in U", utag(2), 8'h31);
    check("R5 next pair in decode", utag(1), 8'h10);
    check("R10 held input taken", utag(0), 8'hC0);
    check("R10 taken once", int'(u_vld[1:0]), 3);
    @(negedge clk);
    check("R3 paired after split", vtag(2), 8'h11);
    drain();

    // R8: reset with a full pipe
    drive(VT[0], 2'b11);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    in_vld = 2'b00;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid-run reset u", int'(u_vld), 0);
    check("R8 mid-run reset v", int'(v_vld), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule